// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management master for clause-22 PHY access. Software programs a control register with the MDC divisor and a preamble enable, then writes one 32-bit command word into the data register. That word already holds the whole frame: start code, opcode, PHY address, register address, turnaround pattern and write data. When the start bit is set, the block produces MDC from the system clock and shifts the frame out on MDIO, most significant bit first. An optional run of 32 ones goes before it.

On a read command, the block releases MDIO for the turnaround and data phases. It shifts in the 16 bits returned by the PHY and stores them in the low half of the data register. At the end of every frame a sticky completion bit is set in the status register. Software clears that bit by writing a one to it. With the typical divisor of 13, a full 64-bit frame takes 1792 system clocks. At common system clock rates this is far below the roughly one millisecond software allows.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, MDC is low, the MDIO output enable is low, and the control (address 0), data (address 1) and status (address 2) registers all read zero.
- R2: While a frame runs, MDC toggles every divisor+1 system clocks, so its period is 2*(divisor+1) clocks, where the divisor is control bits 6:0. MDC stays low when no frame is running.
- R3: A command written to the data register with bit 30 set launches a frame. The frame is 32 MDC cycles: a 0, then command bits 30 down to 0, each driven for one MDC cycle. On a write command (bit 28), MDIO is driven for every one of those cycles.
- R4: With control bit 7 set, 32 consecutive ones go out before the frame, giving 64 MDC cycles. With bit 7 clear there is no preamble.
- R5: MDIO and its output enable change only on a falling MDC edge. They stay constant while MDC is high, and each bit is presented before the rising edge at which it is sampled.
- R6: On a read command (bit 29), the output enable is low for the last 18 bit times (turnaround and data). The PHY's 16 data bits are sampled on rising MDC edges, MSB first. Once the frame completes, they appear in data register bits 15:0, while bits 31:16 keep the command.
- R7: Status bit 0 is set when a frame completes and stays set until a write with bit 0 set. A write of 0 to the status register leaves it set.
- R8: A write to the data register while a frame is in progress is ignored. No new frame starts and the data register keeps its value.
- R9: A command written with bit 30 clear is stored in the data register, starts no frame and does not set the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read (0 control, 1 data, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (low releases the line) |

## Verification
A miscounted bit counter shows up at the pins within one frame. The PHY sees too many or too few MDC cycles, or the turnaround release lands on the wrong bit. A read then returns data shifted by one or more bits in the data register. A divisor error is visible at the second rising MDC edge as a wrong period. A lost or misordered completion update shows up at the first status poll after the frame: the bit stays clear, stays set despite a clear, or comes back set after an ignored command.

// File: rtl/mdio_cmd_pkg.sv
// Shared constants for the MDIO command controller: register addresses,
// command word field positions and frame geometry.
package mdio_cmd_pkg;
    localparam int REG_W      = 32;  // register and command word width
    localparam int DIV_W      = 7;   // MDC divisor field width
    localparam int PRE_LEN    = 32;  // preamble length in bits
    localparam int DATA_LEN   = 16;  // data phase length in bits
    localparam int TA_LEN     = 2;   // turnaround length in bits

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CMD_START_BIT = 30; // launch bit, also second start code bit
    localparam int CMD_READ_BIT  = 29; // read opcode bit
    localparam int CTRL_PRE_BIT  = 7;  // preamble enable in control register
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator. Counts system clocks while run is high and toggles mdc
// every div+1 clocks. Emits one-cycle ticks in the cycle before each edge.
// Assumes div is held constant during a frame; mdc parks low when idle.
module mdio_mdc_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    // Terminal count reached: the next edge toggles mdc.
    always_comb begin
        tick      = run && (cnt_q == div);
        rise_tick = tick && !mdc_q;
        fall_tick = tick && mdc_q;
    end

    // Divider counter and mdc flop, cleared whenever no frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine. Loads preamble plus command into one shift register,
// shifts it out on falling MDC ticks, releases MDIO for the turnaround
// and data of a read, and samples data on rising MDC ticks.
// Assumes launch is only presented while idle.
module mdio_frame_engine #(
    parameter int PRE_LEN   = 32,
    parameter int FRAME_LEN = 32,
    parameter int DATA_LEN  = 16,
    parameter int TA_LEN    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [FRAME_LEN-1:0] cmd,
    input  logic                 pre_en,
    input  logic                 rd_op,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 done,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_LEN-1:0]  rx_data
);
    localparam int TOT     = PRE_LEN + FRAME_LEN;
    localparam int CNT_W   = $clog2(TOT + 1);
    localparam int RELEASE = DATA_LEN + TA_LEN;

    logic [TOT-1:0]       sh_q;
    logic [CNT_W-1:0]     left_q;
    logic                 busy_q, done_q, rd_q;
    logic [DATA_LEN-1:0]  rx_q;
    logic [FRAME_LEN-1:0] frame;
    logic                 released, in_data;

    // Frame bits: start code 0 followed by the command below its top bit.
    always_comb begin
        frame    = {1'b0, cmd[FRAME_LEN-2:0]};
        released = rd_q && (left_q <= CNT_W'(RELEASE));
        in_data  = rd_q && (left_q <= CNT_W'(DATA_LEN));
    end

    // Load, shift, sample and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (launch && !busy_q) begin
                sh_q   <= pre_en ? {{PRE_LEN{1'b1}}, frame} : {frame, {PRE_LEN{1'b0}}};
                left_q <= pre_en ? CNT_W'(TOT) : CNT_W'(FRAME_LEN);
                busy_q <= 1'b1;
                rd_q   <= rd_op;
            end else if (busy_q) begin
                if (rise_tick && in_data)
                    rx_q <= {rx_q[DATA_LEN-2:0], mdio_i};
                if (fall_tick) begin
                    sh_q   <= sh_q << 1;
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign mdio_oe = busy_q && !released;
    assign mdio_o  = sh_q[TOT-1];
    assign rx_data = rx_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
// MDIO command controller top. Holds the control, data and status
// registers, launches frames from data register writes with the start
// bit set, and folds read data and completion back into the registers.
// Assumes a single register port with combinational read of reg_addr.
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    localparam int CTRL_W = DIV_W + 1;

    logic [CTRL_W-1:0]   ctrl_q;
    logic [REG_W-1:0]    data_q;
    logic                status_flag;
    logic                eng_busy, eng_done, frame_active;
    logic                rise_tick, fall_tick;
    logic                launch, wr_data, wr_ctrl, wr_stat;
    logic                rd_q;
    logic [DATA_LEN-1:0] rx_data;

    // Decode register writes; data writes are blocked for a whole frame.
    always_comb begin
        frame_active = eng_busy || eng_done;
        wr_ctrl      = reg_wr && (reg_addr == ADDR_CTRL);
        wr_stat      = reg_wr && (reg_addr == ADDR_STAT);
        wr_data      = reg_wr && (reg_addr == ADDR_DATA) && !frame_active;
        launch       = wr_data && reg_wdata[CMD_START_BIT];
    end

    // Control register: divisor and preamble enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    // Data register: command word, low half replaced by read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            rd_q   <= 1'b0;
        end else if (wr_data) begin
            data_q <= reg_wdata;
            rd_q   <= reg_wdata[CMD_READ_BIT];
        end else if (eng_done && rd_q) begin
            data_q[DATA_LEN-1:0] <= rx_data;
        end
    end

    // Sticky completion flag, write one to clear; completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                      status_flag <= 1'b0;
        else if (eng_done)               status_flag <= 1'b1;
        else if (wr_stat && reg_wdata[0]) status_flag <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_DATA: reg_rdata = data_q;
            ADDR_STAT: reg_rdata = {{(REG_W-1){1'b0}}, status_flag};
            default:   reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (eng_busy),
        .div       (ctrl_q[DIV_W-1:0]),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine #(
        .PRE_LEN   (PRE_LEN),
        .FRAME_LEN (REG_W),
        .DATA_LEN  (DATA_LEN),
        .TA_LEN    (TA_LEN)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd       (reg_wdata),
        .pre_en    (ctrl_q[CTRL_PRE_BIT]),
        .rd_op     (reg_wdata[CMD_READ_BIT]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (eng_busy),
        .done      (eng_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
// Property checker for mdio_cmd_ctrl, attached by bind below.
// Observes ports plus engine and register state of the top.
module mdio_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        frame_active,
    input logic        eng_busy,
    input logic        eng_done,
    input logic        status_flag,
    input logic [31:0] data_q
);
    // R2: no MDC activity outside a frame.
    p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

    // R5: line value and enable hold while MDC is high.
    p_mdio_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7: completion sets the status flag.
    p_done_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> status_flag);

    // R7: flag only drops on a write-one to the status register.
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flag && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> status_flag);

    // R8: data register write during a frame leaves the register alone.
    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && eng_busy) |=> $stable(data_q));

    // R9: a command without the start bit starts nothing.
    p_no_start_no_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !frame_active && !reg_wdata[30]) |=> !eng_busy);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .mdc          (mdc),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .frame_active (frame_active),
    .eng_busy     (eng_busy),
    .eng_done     (eng_done),
    .status_flag  (status_flag),
    .data_q       (data_q)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
// Directed bench for mdio_cmd_ctrl with a behavioural PHY on the pins.
module mdio_cmd_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    // PHY model state
    logic        cap_bit [0:63];
    logic        cap_oe  [0:63];
    time         rise_t  [0:63];
    int          idx = 0;
    int          frame_len = 32;
    logic [15:0] phy_word = 16'h0000;

    always #10 clk = ~clk;

    mdio_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // Record what the PHY sees at each rising MDC edge.
    always @(posedge mdc) begin
        if (idx < 64) begin
            cap_bit[idx] = mdio_o;
            cap_oe[idx]  = mdio_oe;
            rise_t[idx]  = $time;
        end
        idx = idx + 1;
    end

    // PHY drives read data after each falling MDC edge.
    always @(negedge mdc) begin
        if (idx >= frame_len - 16 && idx < frame_len)
            mdio_i <= phy_word[15 - (idx - (frame_len - 16))];
        else
            mdio_i <= 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = 0;
        for (int n = 0; n < 5000 && s[0] !== 1'b1; n++) reg_read(2'd2, s);
        chk(req, s, 32'd1);
    endtask

    task automatic launch(input logic [7:0] ctrl, input logic [31:0] cmd);
        reg_write(2'd0, {24'd0, ctrl});
        idx = 0;
        frame_len = ctrl[7] ? 64 : 32;
        reg_write(2'd1, cmd);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 mdc", {31'd0, mdc}, 32'd0);
        chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
        reg_read(2'd0, d); chk("R1 ctrl", d, 32'd0);
        reg_read(2'd1, d); chk("R1 data", d, 32'd0);
        reg_read(2'd2, d); chk("R1 status", d, 32'd0);
    endtask

    task automatic t_write_frame(input logic pre, input logic [6:0] div, input logic [31:0] cmd);
        logic [31:0] d;
        int bad_bit, bad_oe, off;
        launch({pre, div}, cmd);
        wait_done("R7 completion");
        off = pre ? 32 : 0;
        chk("R4 frame length", idx, pre ? 64 : 32);
        bad_bit = 0; bad_oe = 0;
        for (int i = 0; i < off; i++) if (cap_bit[i] !== 1'b1) bad_bit++;
        chk("R4 preamble ones", bad_bit, 0);
        bad_bit = 0;
        for (int i = 0; i < 32; i++) begin
            if (cap_bit[off + i] !== ((i == 0) ? 1'b0 : cmd[31 - i])) bad_bit++;
            if (cap_oe[off + i] !== 1'b1) bad_oe++;
        end
        chk("R3 frame bits", bad_bit, 0);
        chk("R3 oe driven", bad_oe, 0);
        chk("R2 mdc period", 32'(rise_t[1] - rise_t[0]), 32'(2 * (div + 1) * 20));
        reg_read(2'd1, d); chk("R3 data reg kept", d, cmd);
        reg_write(2'd2, 32'd0);
        reg_read(2'd2, d); chk("R7 write zero keeps flag", d, 32'd1);
        reg_write(2'd2, 32'd1);
        reg_read(2'd2, d); chk("R7 write one clears", d, 32'd0);
    endtask

    task automatic t_read_frame(input logic pre, input logic [6:0] div, input logic [31:0] cmd, input logic [15:0] w);
        logic [31:0] d;
        int bad_bit, bad_oe, off;
        phy_word = w;
        launch({pre, div}, cmd);
        wait_done("R6 completion");
        off = pre ? 32 : 0;
        bad_bit = 0; bad_oe = 0;
        for (int i = 0; i < 14; i++)
            if (cap_bit[off + i] !== ((i == 0) ? 1'b0 : cmd[31 - i])) bad_bit++;
        for (int i = 0; i < 32; i++)
            if (cap_oe[off + i] !== (i < 14)) bad_oe++;
        chk("R6 header bits", bad_bit, 0);
        chk("R6 release window", bad_oe, 0);
        reg_read(2'd1, d); chk("R6 read data", d, {cmd[31:16], w});
        reg_write(2'd2, 32'd1);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] d;
        int n_after;
        launch(8'd3, 32'h5082_1234);
        repeat (200) @(negedge clk);
        reg_write(2'd1, 32'h6006_0000);
        wait_done("R8 first frame done");
        n_after = idx;
        repeat (3000) @(negedge clk);
        chk("R8 no second frame", idx, n_after);
        chk("R8 frame length", n_after, 32);
        reg_read(2'd1, d); chk("R8 data unchanged", d, 32'h5082_1234);
        reg_write(2'd2, 32'd1);
    endtask

    task automatic t_no_start;
        logic [31:0] d;
        launch(8'd1, 32'h1234_5678);
        repeat (500) @(negedge clk);
        chk("R9 no mdc edges", idx, 0);
        reg_read(2'd1, d); chk("R9 stored", d, 32'h1234_5678);
        reg_read(2'd2, d); chk("R9 no completion", d, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_frame(1'b0, 7'd2, 32'h508A_C3A5);
        t_write_frame(1'b1, 7'd0, 32'h50F6_5A5A);
        t_write_frame(1'b0, 7'd13, 32'h5043_8001);
        t_read_frame(1'b0, 7'd1, 32'h60C6_0000, 16'hB38D);
        t_read_frame(1'b1, 7'd2, 32'h6042_FFFF, 16'h8001);
        t_busy_ignore;
        t_no_start;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule